// File: doc/BRIEF.md
# Registered Command Buffer with Select Gating

This block is the register stage on the command/address path of a memory module. Every rising clock edge it captures a data bus together with three side-band bits: a chip select, a clock enable and a termination enable. One configuration input picks between two shapes. The first is a 25-bit register with one output per input bit. The second is a 14-bit register whose result is driven twice, onto bank A and bank B. In the 14-bit shape a second configuration input picks which input positions feed the 14 lanes.

The data outputs are guarded by two active-low selects. If both selects are high, the data outputs keep their last value. If either select is low, the data outputs follow the bus. The three side-band outputs are registered on every edge, whatever the selects are.

An active-low reset clears everything at once, without a clock edge, and it overrides the selects. Its release passes through a two-stage synchronizer. Tying the second select low turns the block into a plain pipeline register.

Top module: `cmdbuf_top`

## Requirements
- R1: With `cfg_split`=0 and at least one select low at a rising edge, `q_a` equals `d_in` from that edge and `q_b` is all zeros.
- R2: With `cfg_split`=1 and `cfg_alt`=0, lane i (i = 0..13) of both `q_b` and `q_a[13:0]` takes `d_in[i]`, and `q_a[24:14]` is zero.
- R3: With `cfg_split`=1 and `cfg_alt`=1, lane i of both `q_b` and `q_a[13:0]` takes `d_in[(2*i+1) mod 25]`, and `q_a[24:14]` is zero.
- R4: `cfg_alt` has no effect while `cfg_split`=0, so the outputs match R1.
- R5: At an edge where `dsel_n` and `rsel_n` are both 1, `q_a` and `q_b` keep their previous values.
- R6: With `rsel_n` held at 0, the data outputs take new data on every edge, whatever `dsel_n` is.
- R7: Bit 0 of `cs_q_n`, `cke_q` and `odt_q` registers `dsel_n`, `cke_in` and `odt_in` on every edge, ignoring the selects. Bit 1 is a copy of bit 0 when `cfg_split`=1 and is 0 otherwise.
- R8: While `rst_n` is 0, every output is 0 from the moment reset asserts, with no clock edge needed, even when a select is low.
- R9: After `rst_n` rises, the outputs stay 0 through the next two rising edges. The third rising edge is the first to capture inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | 0: 25-bit 1:1, 1: 14-bit 1:2 |
| cfg_alt | input | 1 | Lane mapping in 1:2 shape (0 direct, 1 alternate) |
| dsel_n | input | 1 | Active-low select; also the registered chip select |
| rsel_n | input | 1 | Second active-low select |
| cke_in | input | 1 | Clock-enable bit, never gated |
| odt_in | input | 1 | Termination bit, never gated |
| d_in | input | 25 | Command/address data bus |
| q_a | output | 25 | Data outputs, bank A |
| q_b | output | 14 | Data outputs, bank B (zero in 1:1 shape) |
| cs_q_n | output | 2 | Registered chip select, {B copy, A copy} |
| cke_q | output | 2 | Registered clock enable, {B copy, A copy} |
| odt_q | output | 2 | Registered termination, {B copy, A copy} |

## Verification
Two things can happen on the same edge. The data may be held because both selects are high, while the side-band bits still update. Hold runs are driven while `cke_in`, `odt_in` and `dsel_n` change. A scoreboard then expects the data banks to stay frozen and the side-band copies to move in that same cycle.

Reset is also asserted between edges while a select is low and the data is busy. Reset must win at once and stay in force through the next edge. The two edges after release are checked to confirm that the zeros persist until the third edge.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  localparam int unsigned WIDE_W   = 25;
  localparam int unsigned NARROW_W = 14;

  // alternate lane source: odd stride through the wide bus, wrapping
  function automatic int unsigned alt_src(input int unsigned lane, input int unsigned wide);
    return (2 * lane + 1) % wide;
  endfunction
endpackage

// File: rtl/cmdbuf_rst_sync.sv
module cmdbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q & rst_n;
endmodule

// File: rtl/cmdbuf_hold_reg.sv
module cmdbuf_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/cmdbuf_lane_map.sv
module cmdbuf_lane_map #(
  parameter int unsigned WIDE_W   = cmdbuf_pkg::WIDE_W,
  parameter int unsigned NARROW_W = cmdbuf_pkg::NARROW_W
) (
  input  logic                split,
  input  logic                alt,
  input  logic [WIDE_W-1:0]   d,
  output logic [WIDE_W-1:0]   a_nxt,
  output logic [NARROW_W-1:0] b_nxt
);
  localparam int unsigned PAD_W = WIDE_W - NARROW_W;

  logic [NARROW_W-1:0] lane_dir;
  logic [NARROW_W-1:0] lane_alt;
  logic [NARROW_W-1:0] lane_sel;

  for (genvar i = 0; i < NARROW_W; i++) begin : g_lane
    localparam int unsigned SRC = cmdbuf_pkg::alt_src(i, WIDE_W);
    assign lane_dir[i] = d[i];
    assign lane_alt[i] = d[SRC];
  end

  always_comb begin
    lane_sel = alt ? lane_alt : lane_dir;
    if (split) begin
      a_nxt = {{PAD_W{1'b0}}, lane_sel};
      b_nxt = lane_sel;
    end else begin
      a_nxt = d;
      b_nxt = '0;
    end
  end
endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top #(
  parameter int unsigned WIDE_W   = cmdbuf_pkg::WIDE_W,
  parameter int unsigned NARROW_W = cmdbuf_pkg::NARROW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_split,
  input  logic                cfg_alt,
  input  logic                dsel_n,
  input  logic                rsel_n,
  input  logic                cke_in,
  input  logic                odt_in,
  input  logic [WIDE_W-1:0]   d_in,
  output logic [WIDE_W-1:0]   q_a,
  output logic [NARROW_W-1:0] q_b,
  output logic [1:0]          cs_q_n,
  output logic [1:0]          cke_q,
  output logic [1:0]          odt_q
);
  localparam int unsigned SIDE_W = 6;

  logic                rst_sync_n;
  logic                data_en;
  logic [WIDE_W-1:0]   a_nxt;
  logic [NARROW_W-1:0] b_nxt;
  logic [SIDE_W-1:0]   side_nxt;
  logic [SIDE_W-1:0]   side_q;

  cmdbuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmdbuf_lane_map #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_map (
    .split (cfg_split),
    .alt   (cfg_alt),
    .d     (d_in),
    .a_nxt (a_nxt),
    .b_nxt (b_nxt)
  );

  // either active-low select opens the data path
  assign data_en = ~(dsel_n & rsel_n);

  always_comb begin
    side_nxt = {cfg_split & odt_in, odt_in,
                cfg_split & cke_in, cke_in,
                cfg_split & dsel_n, dsel_n};
  end

  cmdbuf_hold_reg #(.W(WIDE_W)) u_reg_a (
    .clk (clk), .rst_n (rst_sync_n), .en (data_en), .d (a_nxt), .q (q_a)
  );

  cmdbuf_hold_reg #(.W(NARROW_W)) u_reg_b (
    .clk (clk), .rst_n (rst_sync_n), .en (data_en), .d (b_nxt), .q (q_b)
  );

  cmdbuf_hold_reg #(.W(SIDE_W)) u_reg_side (
    .clk (clk), .rst_n (rst_sync_n), .en (1'b1), .d (side_nxt), .q (side_q)
  );

  assign cs_q_n = side_q[1:0];
  assign cke_q  = side_q[3:2];
  assign odt_q  = side_q[5:4];
endmodule

// File: rtl/cmdbuf_chk.sv
module cmdbuf_chk #(
  parameter int unsigned WIDE_W   = cmdbuf_pkg::WIDE_W,
  parameter int unsigned NARROW_W = cmdbuf_pkg::NARROW_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_ok,
  input logic                cfg_split,
  input logic                cfg_alt,
  input logic                dsel_n,
  input logic                rsel_n,
  input logic                cke_in,
  input logic                odt_in,
  input logic [WIDE_W-1:0]   d_in,
  input logic [WIDE_W-1:0]   q_a,
  input logic [NARROW_W-1:0] q_b,
  input logic [1:0]          cs_q_n,
  input logic [1:0]          cke_q,
  input logic [1:0]          odt_q
);
  // R1
  wide_capture_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(!cfg_split && !(dsel_n && rsel_n)))
    |-> (q_a == $past(d_in) && q_b == '0));

  // R2
  split_direct_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cfg_split && !cfg_alt && !(dsel_n && rsel_n)))
    |-> (q_b == $past(d_in[NARROW_W-1:0]) &&
         q_a == {{(WIDE_W-NARROW_W){1'b0}}, q_b}));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(dsel_n && rsel_n))
    |-> ($stable(q_a) && $stable(q_b)));

  // R7
  side_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok)
    |-> (cs_q_n[0] == $past(dsel_n) && cke_q[0] == $past(cke_in) &&
         odt_q[0] == $past(odt_in)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0 && cs_q_n == '0 &&
                cke_q == '0 && odt_q == '0));
endmodule

bind cmdbuf_top cmdbuf_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_sync_n),
  .cfg_split (cfg_split),
  .cfg_alt   (cfg_alt),
  .dsel_n    (dsel_n),
  .rsel_n    (rsel_n),
  .cke_in    (cke_in),
  .odt_in    (odt_in),
  .d_in      (d_in),
  .q_a       (q_a),
  .q_b       (q_b),
  .cs_q_n    (cs_q_n),
  .cke_q     (cke_q),
  .odt_q     (odt_q)
);

// File: tb/cmdbuf_top_tb_top.sv
module cmdbuf_top_tb_top;
  localparam int W = 25;
  localparam int N = 14;

  logic         clk;
  logic         rst_n;
  logic         cfg_split;
  logic         cfg_alt;
  logic         dsel_n;
  logic         rsel_n;
  logic         cke_in;
  logic         odt_in;
  logic [W-1:0] d_in;
  logic [W-1:0] q_a;
  logic [N-1:0] q_b;
  logic [1:0]   cs_q_n;
  logic [1:0]   cke_q;
  logic [1:0]   odt_q;

  typedef struct packed {
    logic [W-1:0] a;
    logic [N-1:0] b;
    logic [1:0]   cs;
    logic [1:0]   ck;
    logic [1:0]   od;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  model;
  int    sync_left;
  string cur_tag;
  int    vectors;
  int    miscompares;
  bit    done;

  cmdbuf_top dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_split (cfg_split), .cfg_alt (cfg_alt),
    .dsel_n (dsel_n), .rsel_n (rsel_n), .cke_in (cke_in), .odt_in (odt_in),
    .d_in (d_in), .q_a (q_a), .q_b (q_b), .cs_q_n (cs_q_n),
    .cke_q (cke_q), .odt_q (odt_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t observed();
    exp_t o;
    o.a = q_a; o.b = q_b; o.cs = cs_q_n; o.ck = cke_q; o.od = odt_q;
    return o;
  endfunction

  task automatic compare(input exp_t act, input exp_t exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got a=%h b=%h cs=%b cke=%b odt=%b, expected a=%h b=%h cs=%b cke=%b odt=%b",
               tag, act.a, act.b, act.cs, act.ck, act.od,
               exp.a, exp.b, exp.cs, exp.ck, exp.od);
    end
  endtask

  // driver: drive at the falling edge, predict the result of the next rising edge
  task automatic apply(input logic split, input logic alt, input logic [W-1:0] d,
                       input logic ds, input logic rs, input logic ck, input logic od);
    logic [N-1:0] lane;
    @(negedge clk);
    cfg_split = split; cfg_alt = alt; d_in = d;
    dsel_n = ds; rsel_n = rs; cke_in = ck; odt_in = od;
    if (sync_left > 0) begin
      sync_left--;
    end else begin
      model.cs = {split & ds, ds};
      model.ck = {split & ck, ck};
      model.od = {split & od, od};
      if (!ds || !rs) begin
        for (int i = 0; i < N; i++)
          lane[i] = alt ? d[(2 * i + 1) % W] : d[i];
        if (split) begin
          model.a = {{(W-N){1'b0}}, lane};
          model.b = lane;
        end else begin
          model.a = d;
          model.b = '0;
        end
      end
    end
    exp_q.push_back(model);
    tag_q.push_back(cur_tag);
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) compare(observed(), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic release_reset();
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    model = '0;
    sync_left = 2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    miscompares++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0; sync_left = 0; model = '0;
    rst_n = 1'b0; cfg_split = 1'b0; cfg_alt = 1'b0; dsel_n = 1'b0; rsel_n = 1'b1;
    cke_in = 1'b1; odt_in = 1'b1; d_in = '1;
    repeat (3) @(posedge clk);
    #5;
    compare(observed(), exp_t'('0), "R8 reset state");

    // R9: two zero edges after release, third captures
    release_reset();
    cur_tag = "R9";
    for (int k = 0; k < 3; k++) apply(1'b0, 1'b0, 25'h1ABCDEF + W'(k), 1'b0, 1'b1, 1'b1, 1'b0);

    cur_tag = "R1";
    apply(1'b0, 1'b0, 25'h0000000, 1'b0, 1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 25'h1FFFFFF, 1'b0, 1'b1, 1'b1, 1'b1);
    apply(1'b0, 1'b0, 25'h0AAAAAA, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++) apply(1'b0, 1'b0, W'($urandom), 1'b0, 1'b0, 1'b1, 1'b0);

    cur_tag = "R4";
    for (int k = 0; k < 8; k++) apply(1'b0, 1'b1, W'($urandom), 1'b0, 1'b1, 1'(k), 1'(k >> 1));

    // R5 and R7 together: data frozen, side bits still move
    cur_tag = "R5/R7 hold";
    apply(1'b0, 1'b0, 25'h1234567, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) apply(1'b0, 1'b0, W'($urandom), 1'b1, 1'b1, 1'(k), 1'(~k));

    cur_tag = "R2";
    for (int k = 0; k < 10; k++) apply(1'b1, 1'b0, W'($urandom), 1'b0, 1'b1, 1'(k), 1'(k >> 1));
    apply(1'b1, 1'b0, 25'h0003FFF, 1'b1, 1'b0, 1'b1, 1'b1);
    apply(1'b1, 1'b0, 25'h1FFC000, 1'b0, 1'b1, 1'b0, 1'b1);

    cur_tag = "R3";
    for (int k = 0; k < 10; k++) apply(1'b1, 1'b1, W'($urandom), 1'b0, 1'b1, 1'(~k), 1'(k));
    apply(1'b1, 1'b1, 25'h0AAAAAA, 1'b1, 1'b0, 1'b0, 1'b0);
    apply(1'b1, 1'b1, 25'h1555555, 1'b0, 1'b0, 1'b1, 1'b0);

    cur_tag = "R5/R7 split hold";
    for (int k = 0; k < 6; k++) apply(1'b1, 1'b1, W'($urandom), 1'b1, 1'b1, 1'(k), 1'(k >> 1));

    cur_tag = "R6";
    for (int k = 0; k < 12; k++) apply(k[2], 1'b0, W'($urandom), 1'(k), 1'b0, 1'(k >> 1), 1'(k));

    // R8: reset between edges, selects open, must clear without an edge
    @(posedge clk);
    #7;
    cfg_split = 1'b1; dsel_n = 1'b0; rsel_n = 1'b0; d_in = '1; cke_in = 1'b1; odt_in = 1'b1;
    rst_n = 1'b0;
    #1;
    compare(observed(), exp_t'('0), "R8 async clear");
    @(posedge clk);
    #5;
    compare(observed(), exp_t'('0), "R8 priority over selects");

    release_reset();
    cur_tag = "R9 second release";
    for (int k = 0; k < 4; k++) apply(1'b1, 1'b0, W'($urandom), 1'b0, 1'b0, 1'b1, 1'b1);

    repeat (3) @(posedge clk);
    #6;
    finish_run();
  end
endmodule